// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

The block sits behind a byte-wide host command channel and turns a stream of one-byte commands into reads and writes of an internal 256-address, 8-bit register space. Every command byte holds an operation code in its upper four bits and a 4-bit argument in its lower four bits. A full register address, or a full data byte, is therefore assembled from two separate commands. Each read command returns one byte on a separate response channel.

The control path is a two-state machine. In `S_ACCEPT` the block takes one command per cycle. A read command moves it to `S_RESPOND` (transition *read-accepted*). It stays there, with the command channel stalled, until the response byte is taken (transition *response-taken*, back to `S_ACCEPT`). All other commands leave the machine in `S_ACCEPT` (transition *non-read-accepted*).

The register space holds four kinds of location. There is a read-only identity byte, a scratch byte for link testing, and one 16-entry page of general read/write storage. Every other address is unimplemented.

Top module: `regcmd_decoder`

## Requirements
- R1: A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Bits 7:4 of the byte hold the operation code and bits 3:0 hold the argument. The codes are: 0x1 address-low, 0x2 address-high, 0x3 data-low, 0x4 data-high-and-write, 0x5 read, 0x6 read-then-increment. Any other code has no effect on the address, the held data nibble or any register.
- R2: Address-low replaces address bits 3:0 and keeps bits 7:4. Address-high replaces bits 7:4 and keeps bits 3:0.
- R3: Data-low stores its argument as a pending low nibble and writes nothing. Data-high-and-write writes {argument, pending low nibble} to the addressed register. Neither command changes the address.
- R4: A taken read raises `rsp_valid` on the next clock edge, with `rsp_byte` equal to the addressed register's contents at the time of the read. Both are held unchanged until a rising edge where `rsp_ready` is high.
- R5: `cmd_ready` is low while a response is pending. Commands presented during that time are not taken. `cmd_ready` is high again from the edge that completes the response handshake.
- R6: Read-then-increment adds one to address bits 3:0 after the read, wrapping from 0xF to 0x0. Bits 7:4 never change, so 16 such reads in a row return every register of one page in rising order and leave the address where it started.
- R7: Address 0x00 is a read-only identity register that returns the parameter `ID_VALUE` (default 0xA5). Writes to it are ignored.
- R8: Address 0x01 is a scratch register that reads back exactly the last byte written, for example 0x55 and then 0xAA.
- R9: Addresses 0x10 to 0x1F form a page of read/write storage, each entry independent.
- R10: Every other address reads as 0xFF, and writes to it are ignored.
- R11: After reset `cmd_ready` is high, `rsp_valid` is low, and both the address and the pending low nibble are zero. All writable registers reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_byte | input | 8 | Operation code (7:4) and argument (3:0) |
| rsp_valid | output | 1 | Read response byte pending |
| rsp_ready | input | 1 | Host takes the response byte |
| rsp_byte | output | 8 | Register contents returned by a read |

## Verification
A write takes effect on the edge that accepts the data-high command. A read issued straight after it therefore already sees the new value. A read's response is due exactly one edge after the read is accepted. The bench drives every input on falling edges and checks `rsp_valid` and `rsp_byte` at the first falling edge after the accepting edge. It then checks `cmd_ready` again one edge after asserting `rsp_ready`. The stall window is checked across several held cycles, during which a write is offered and must not be taken.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    // Operation codes carried in the upper nibble of each command byte.
    localparam logic [NIB_W-1:0] OP_ADDR_LO    = 4'h1;
    localparam logic [NIB_W-1:0] OP_ADDR_HI    = 4'h2;
    localparam logic [NIB_W-1:0] OP_DATA_LO    = 4'h3;
    localparam logic [NIB_W-1:0] OP_DATA_HI_WR = 4'h4;
    localparam logic [NIB_W-1:0] OP_READ       = 4'h5;
    localparam logic [NIB_W-1:0] OP_READ_INC   = 4'h6;

    typedef enum logic {
        S_ACCEPT  = 1'b0,
        S_RESPOND = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [BYTE_W-1:0] rsp_byte,
    output logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [BYTE_W-1:0] reg_wdata
);

    ctl_state_t        state_q, state_d;
    logic [NIB_W-1:0]  addr_hi_q, addr_lo_q, data_lo_q;
    logic [BYTE_W-1:0] rsp_q;
    logic [NIB_W-1:0]  op, arg;
    logic              take;
    logic              is_read;

    assign op      = cmd_byte[BYTE_W-1:NIB_W];
    assign arg     = cmd_byte[NIB_W-1:0];
    assign is_read = (op == OP_READ) || (op == OP_READ_INC);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_ACCEPT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACCEPT:  if (take && is_read) state_d = S_RESPOND;
            S_RESPOND: if (rsp_ready)       state_d = S_ACCEPT;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            S_ACCEPT:  cmd_ready = 1'b1;
            S_RESPOND: rsp_valid = 1'b1;
        endcase
        take      = cmd_valid && cmd_ready;
        reg_we    = take && (op == OP_DATA_HI_WR);
        reg_wdata = {arg, data_lo_q};
        reg_addr  = {addr_hi_q, addr_lo_q};
        rsp_byte  = rsp_q;
    end

    // Datapath: address, pending nibble, response byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            data_lo_q <= '0;
            rsp_q     <= '0;
        end else if (take) begin
            case (op)
                OP_ADDR_LO: addr_lo_q <= arg;
                OP_ADDR_HI: addr_hi_q <= arg;
                OP_DATA_LO: data_lo_q <= arg;
                OP_READ:    rsp_q     <= reg_rdata;
                OP_READ_INC: begin
                    rsp_q     <= reg_rdata;
                    addr_lo_q <= addr_lo_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R5
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte))); // R4
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && is_read) |=> (rsp_valid && rsp_byte == $past(reg_rdata))); // R4
    AST_INC_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op == OP_READ_INC) |=>
        (reg_addr[BYTE_W-1:NIB_W] == $past(reg_addr[BYTE_W-1:NIB_W]) &&
         reg_addr[NIB_W-1:0] == NIB_W'($past(reg_addr[NIB_W-1:0]) + 1'b1))); // R6
    AST_ADDR_LO_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op == OP_ADDR_LO) |=>
        $stable(reg_addr[BYTE_W-1:NIB_W])); // R2
    AST_WRITE_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $stable(reg_addr)); // R3

endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile
    import regcmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_VALUE     = 8'hA5,
    parameter logic [BYTE_W-1:0] ID_ADDR      = 8'h00,
    parameter logic [BYTE_W-1:0] SCRATCH_ADDR = 8'h01,
    parameter logic [NIB_W-1:0]  USER_PAGE    = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    localparam int PAGE_SIZE = 1 << NIB_W;

    logic [BYTE_W-1:0] scratch_q;
    logic [BYTE_W-1:0] user_q [PAGE_SIZE];
    logic              in_user;

    assign in_user = (addr[BYTE_W-1:NIB_W] == USER_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         scratch_q <= '0;
        else if (we && addr == SCRATCH_ADDR) scratch_q <= wdata;
    end

    for (genvar i = 0; i < PAGE_SIZE; i++) begin : g_user
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                user_q[i] <= '0;
            else if (we && in_user && addr[NIB_W-1:0] == NIB_W'(i))
                user_q[i] <= wdata;
        end
    end

    always_comb begin
        if (addr == ID_ADDR)           rdata = ID_VALUE;
        else if (addr == SCRATCH_ADDR) rdata = scratch_q;
        else if (in_user)              rdata = user_q[addr[NIB_W-1:0]];
        else                           rdata = '1;
    end

    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ID_ADDR) |-> (rdata == ID_VALUE)); // R7
    AST_SCRATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SCRATCH_ADDR) |=> (scratch_q == $past(wdata))); // R8
    AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == SCRATCH_ADDR) |=> $stable(scratch_q)); // R8

endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
    import regcmd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_VALUE     = 8'hA5,
    parameter logic [BYTE_W-1:0] ID_ADDR      = 8'h00,
    parameter logic [BYTE_W-1:0] SCRATCH_ADDR = 8'h01,
    parameter logic [NIB_W-1:0]  USER_PAGE    = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [BYTE_W-1:0] rsp_byte
);

    logic [BYTE_W-1:0] reg_addr, reg_rdata, reg_wdata;
    logic              reg_we;

    regcmd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_byte  (cmd_byte),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_byte  (rsp_byte),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata)
    );

    regcmd_regfile #(
        .ID_VALUE     (ID_VALUE),
        .ID_ADDR      (ID_ADDR),
        .SCRATCH_ADDR (SCRATCH_ADDR),
        .USER_PAGE    (USER_PAGE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata)
    );

endmodule

// File: tb/regcmd_decoder_test.sv
module regcmd_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       rsp_ready = 1'b0;
    logic       cmd_ready, rsp_valid;
    logic [7:0] rsp_byte;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] umem [16];
    logic [7:0] scratch_m;

    always #4 clk = ~clk;   // 125 MHz

    regcmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_byte(rsp_byte)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung (actual cycles %0d, expected completion)", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] a);
        if (a == 8'h00)         return 8'hA5;
        else if (a == 8'h01)    return scratch_m;
        else if (a[7:4] == 4'h1) return umem[a[3:0]];
        else                    return 8'hFF;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        send({4'h2, a[7:4]});
        send({4'h1, a[3:0]});
    endtask

    task automatic write_byte(input logic [7:0] d);
        send({4'h3, d[3:0]});
        send({4'h4, d[7:4]});
    endtask

    task automatic do_read(input bit inc, input logic [7:0] exp, input string req);
        send({inc ? 4'h6 : 4'h5, 4'h0});
        check({req, " rsp_valid"}, {7'd0, rsp_valid}, 8'd1);
        check(req, rsp_byte, exp);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check({req, " R5 ready after handshake"}, {7'd0, cmd_ready}, 8'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) umem[i] = 8'h00;
        scratch_m = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 cmd_ready", {7'd0, cmd_ready}, 8'd1);
        check("R11 rsp_valid", {7'd0, rsp_valid}, 8'd0);
        do_read(0, 8'hA5, "R11 address zero reads R7 id");
        // R11 pending nibble resets to zero; R3 write uses it
        send(8'h11);
        send(8'h47);
        scratch_m = 8'h70;
        do_read(0, 8'h70, "R11 R3 pending nibble zero");

        // R8 scratch pattern
        write_byte(8'h55); scratch_m = 8'h55;
        do_read(0, 8'h55, "R8 scratch 55");
        write_byte(8'hAA); scratch_m = 8'hAA;
        do_read(0, 8'hAA, "R8 scratch AA");

        // R3 data-low alone writes nothing
        send(8'h3C);
        do_read(0, 8'hAA, "R3 data-low no write");
        send(8'h43); scratch_m = 8'h3C;
        do_read(0, 8'h3C, "R3 write on high nibble");

        // R5 stall: pending response blocks a write offered meanwhile
        send(8'h50);
        cmd_valid = 1'b1; cmd_byte = 8'h49;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 cmd_ready low while pending", {7'd0, cmd_ready}, 8'd0);
            check("R4 response held", rsp_byte, 8'h3C);
        end
        cmd_valid = 1'b0;
        rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
        check("R5 ready after handshake", {7'd0, cmd_ready}, 8'd1);
        do_read(0, 8'h3C, "R5 stalled write not taken");

        // R7 id write ignored
        set_addr(8'h00);
        write_byte(8'h12);
        do_read(0, 8'hA5, "R7 id write ignored");

        // R1/R2/R3/R9/R10: write every address, then read every address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] v;
            v = 8'(a * 7 + 3);
            set_addr(8'(a));
            write_byte(v);
            if (a == 1) scratch_m = v;
            else if (a[7:4] == 4'h1) umem[a[3:0]] = v;
        end
        for (int a = 0; a < 256; a++) begin
            set_addr(8'(a));
            do_read(0, model(8'(a)), "R9 R10 sweep");
        end

        // R2 address-low keeps page; address-high keeps low nibble
        set_addr(8'h13);
        send(8'h17);
        do_read(0, umem[7], "R2 addr-low keeps page");
        send(8'h20);
        do_read(0, 8'hFF, "R2 addr-high keeps low nibble");
        send(8'h21);
        do_read(0, umem[7], "R2 addr-high back to page 1");

        // R1 unknown opcodes have no effect
        send(8'hF3); send(8'h0A); send(8'h98);
        do_read(0, umem[7], "R1 unknown opcode no address change");
        set_addr(8'h01);
        send(8'h3E); send(8'h7F);
        send(8'h42); scratch_m = 8'h2E;
        do_read(0, 8'h2E, "R1 unknown opcode keeps nibble");

        // R10 write to unmapped ignored
        set_addr(8'h35);
        write_byte(8'h00);
        do_read(0, 8'hFF, "R10 unmapped write ignored");

        // R6 incrementing burst wraps within page
        set_addr(8'h1A);
        for (int i = 0; i < 16; i++)
            do_read(1, umem[(i + 10) % 16], "R6 burst");
        do_read(0, umem[10], "R6 address back to start");
        set_addr(8'h0F);
        do_read(1, 8'hFF, "R6 read at 0F");
        do_read(0, 8'hA5, "R6 wrap 0F to 00 not 10");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule